// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

A single DMA channel that executes a chain of transfer descriptors stored in memory. Each descriptor occupies four consecutive words and describes one copy: how many bytes, where to read them, where to write them, and where the next descriptor lives. Software programs the address of the first descriptor, raises the start bit in the mode register, and the channel walks the chain without further help. It fetches each descriptor over a word-read port and copies the bytes one at a time over a byte read/write port.

The channel stops after the descriptor whose link word carries the end-of-list flag, and records the outcome in a status register. That register combines sticky write-one-to-clear event bits with two live bits that show whether the channel is busy or halted. A single interrupt line reports chain completion and, separately enabled, error events. Software can abort a running chain at any point. The channel halts by itself on a zero-length descriptor or on an error response from either memory port.

Register map (reg_addr_i): 0 = mode, 1 = status, 2 = current descriptor address. Mode bits: 0 start, 1 abort (write-only strobe, reads 0), 2 completion interrupt enable, 3 error interrupt enable. Status bits: 0 chain done, 1 zero-length error, 2 memory error, 4 busy, 5 halted; all other bits read 0.

Top module: `ldma_chan`

## Requirements
- R1: After reset the mode, status and descriptor-address registers read 0 and irq_o is low.
- R2: A descriptor at word address A holds the byte count at A (bits CW-1:0), the source address at A+1, the destination address at A+2 and the link word at A+3. The channel copies count bytes from source to destination at ascending addresses.
- R3: Link word bits AW-1:2 give the next descriptor address, with its two low bits forced to zero, and bit 0 flags the last descriptor. After that descriptor the channel fetches nothing more.
- R4: A mode write that sets the start bit begins the chain at the descriptor-address register, but only when the stored start bit is 0 and the channel is not busy. Writing start as 1 while it already reads 1 starts nothing. The memory ports stay quiet while the channel is not busy.
- R5: Status bit 4 (busy) reads 1 while a chain is processed. Status bit 5 (halted) is set when the channel stops by abort or error and is cleared by the next start. The two bits are never both set.
- R6: Finishing the last descriptor sets status bit 0, clears busy and leaves halted clear. irq_o is high while bit 0 and mode bit 2 are both set.
- R7: A mode write with bit 1 set while busy ends the chain on the next clock edge: busy clears, halted sets, and no further memory writes occur.
- R8: A descriptor whose count is 0 sets status bit 1 and moves no data, and the channel halts.
- R9: An error response on either memory port sets status bit 2 and halts the channel. Bytes written before the failing access remain.
- R10: Writing the status register clears exactly those event bits (0 to 2) written as 1; bits written as 0 keep their value.
- R11: The descriptor-address register reads back the address of the descriptor being processed. It advances to each linked descriptor and holds the last one after completion; software writes to it take effect only while not busy.
- R12: irq_o is high while status bit 1 or 2 is set and mode bit 3 is set, and low when bit 3 is clear and no enabled event is pending.
- R13: A memory request holds its address, and its write flag, unchanged until acknowledged, unless an abort intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on reg_addr_i) |
| dsc_req_o | output | 1 | Descriptor word read request |
| dsc_addr_o | output | AW | Descriptor word address |
| dsc_ack_i | input | 1 | Descriptor read acknowledge |
| dsc_err_i | input | 1 | Descriptor read error, valid with acknowledge |
| dsc_rdata_i | input | 32 | Descriptor read data, valid with acknowledge |
| mem_req_o | output | 1 | Data byte access request |
| mem_we_o | output | 1 | Data access is a write |
| mem_addr_o | output | AW | Data byte address |
| mem_wdata_o | output | 8 | Data byte to write |
| mem_ack_i | input | 1 | Data access acknowledge |
| mem_err_i | input | 1 | Data access error, valid with acknowledge |
| mem_rdata_i | input | 8 | Data byte read, valid with acknowledge |
| irq_o | output | 1 | Interrupt |

## Verification
The assertions assume that each memory port acknowledges a request in the same cycle or later while the request is held, that data and error flags matter only together with acknowledge, and that software issues an abort only through a mode write. The bench memory models acknowledge combinationally from a ready flag that is randomised at the falling edge, so requests see zero or several wait cycles. Error responses are injected at single chosen addresses. The bench writes the descriptor address only while the channel is idle. It always clears the start bit and the event bits before launching a new chain, except in the directed case that checks a repeated start has no effect.

// File: rtl/ldma_pkg.sv
package ldma_pkg;
  localparam int BYTE_W = 8;

  localparam logic [1:0] REG_MODE = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_CDA  = 2'd2;

  localparam int MB_START = 0;
  localparam int MB_ABORT = 1;
  localparam int MB_DNIE  = 2;
  localparam int MB_ERRIE = 3;

  localparam int SB_DONE = 0;
  localparam int SB_ZLEN = 1;
  localparam int SB_MERR = 2;
  localparam int SB_BUSY = 4;
  localparam int SB_HALT = 5;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_COPY} seq_e;
  typedef enum logic [1:0] {C_IDLE, C_RD, C_WR} cpy_e;
endpackage

// File: rtl/ldma_regs.sv
module ldma_regs
  import ldma_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          busy_i,
  input  logic          halted_i,
  input  logic          ev_done_i,
  input  logic          ev_zlen_i,
  input  logic          ev_merr_i,
  input  logic          cda_ld_i,
  input  logic [AW-1:0] cda_nxt_i,
  output logic [AW-1:0] cda_o,
  output logic          go_o,
  output logic          abort_o,
  output logic          irq_o
);
  logic start_q, dnie_q, errie_q;
  logic done_q, zlen_q, merr_q;
  logic [AW-1:0] cda_q;
  logic wr_mode, wr_stat, wr_cda;
  logic unused_w;

  assign wr_mode = reg_we_i && (reg_addr_i == REG_MODE);
  assign wr_stat = reg_we_i && (reg_addr_i == REG_STAT);
  assign wr_cda  = reg_we_i && (reg_addr_i == REG_CDA);
  assign go_o    = wr_mode && reg_wdata_i[MB_START] && !start_q && !busy_i;
  assign abort_o = wr_mode && reg_wdata_i[MB_ABORT] && busy_i;
  assign unused_w = ^reg_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      dnie_q  <= 1'b0;
      errie_q <= 1'b0;
      done_q  <= 1'b0;
      zlen_q  <= 1'b0;
      merr_q  <= 1'b0;
      cda_q   <= '0;
    end else begin
      if (wr_mode) begin
        start_q <= reg_wdata_i[MB_START];
        dnie_q  <= reg_wdata_i[MB_DNIE];
        errie_q <= reg_wdata_i[MB_ERRIE];
      end
      // set wins over a same-cycle clear
      done_q <= ev_done_i | (done_q & ~(wr_stat & reg_wdata_i[SB_DONE]));
      zlen_q <= ev_zlen_i | (zlen_q & ~(wr_stat & reg_wdata_i[SB_ZLEN]));
      merr_q <= ev_merr_i | (merr_q & ~(wr_stat & reg_wdata_i[SB_MERR]));
      if (cda_ld_i)
        cda_q <= cda_nxt_i;
      else if (wr_cda && !busy_i)
        cda_q <= {reg_wdata_i[AW-1:2], 2'b00};
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_MODE: begin
        reg_rdata_o[MB_START] = start_q;
        reg_rdata_o[MB_DNIE]  = dnie_q;
        reg_rdata_o[MB_ERRIE] = errie_q;
      end
      REG_STAT: begin
        reg_rdata_o[SB_DONE] = done_q;
        reg_rdata_o[SB_ZLEN] = zlen_q;
        reg_rdata_o[SB_MERR] = merr_q;
        reg_rdata_o[SB_BUSY] = busy_i;
        reg_rdata_o[SB_HALT] = halted_i;
      end
      REG_CDA:  reg_rdata_o[AW-1:0] = cda_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign cda_o = cda_q;
  assign irq_o = (done_q & dnie_q) | ((zlen_q | merr_q) & errie_q);
endmodule

// File: rtl/ldma_copy.sv
module ldma_copy
  import ldma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [AW-1:0]     src_i,
  input  logic [AW-1:0]     dst_i,
  input  logic [CW-1:0]     cnt_i,
  output logic              done_o,
  output logic              err_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [BYTE_W-1:0] mem_rdata_i
);
  cpy_e st_q;
  logic [AW-1:0] sa_q, da_q;
  logic [CW-1:0] rem_q;
  logic [BYTE_W-1:0] byte_q;

  assign mem_req_o   = (st_q != C_IDLE);
  assign mem_we_o    = (st_q == C_WR);
  assign mem_addr_o  = (st_q == C_WR) ? da_q : sa_q;
  assign mem_wdata_o = byte_q;
  assign err_o  = mem_req_o && mem_ack_i && mem_err_i && !abort_i;
  assign done_o = (st_q == C_WR) && mem_ack_i && !mem_err_i &&
                  (rem_q == CW'(1)) && !abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= C_IDLE;
      sa_q   <= '0;
      da_q   <= '0;
      rem_q  <= '0;
      byte_q <= '0;
    end else if (abort_i) begin
      st_q <= C_IDLE;
    end else begin
      unique case (st_q)
        C_IDLE: if (start_i) begin
          sa_q  <= src_i;
          da_q  <= dst_i;
          rem_q <= cnt_i;
          st_q  <= C_RD;
        end
        C_RD: if (mem_ack_i) begin
          if (mem_err_i) st_q <= C_IDLE;
          else begin
            byte_q <= mem_rdata_i;
            st_q   <= C_WR;
          end
        end
        C_WR: if (mem_ack_i) begin
          if (mem_err_i) st_q <= C_IDLE;
          else begin
            sa_q  <= sa_q + AW'(1);
            da_q  <= da_q + AW'(1);
            rem_q <= rem_q - CW'(1);
            st_q  <= (rem_q == CW'(1)) ? C_IDLE : C_RD;
          end
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldma_seq.sv
module ldma_seq
  import ldma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          abort_i,
  input  logic [AW-1:0] cda_i,
  output logic          dsc_req_o,
  output logic [AW-1:0] dsc_addr_o,
  input  logic          dsc_ack_i,
  input  logic          dsc_err_i,
  input  logic [31:0]   dsc_rdata_i,
  output logic          cp_start_o,
  output logic [AW-1:0] cp_src_o,
  output logic [AW-1:0] cp_dst_o,
  output logic [CW-1:0] cp_cnt_o,
  input  logic          cp_done_i,
  input  logic          cp_err_i,
  output logic          busy_o,
  output logic          halted_o,
  output logic          ev_done_o,
  output logic          ev_zlen_o,
  output logic          ev_merr_o,
  output logic          cda_ld_o,
  output logic [AW-1:0] cda_nxt_o
);
  seq_e st_q;
  logic [1:0] idx_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] src_q, dst_q, nxt_q;
  logic last_q, halted_q;
  logic fetched_w, fin_w, halt_w;
  logic unused_w;

  assign unused_w   = ^dsc_rdata_i;
  assign dsc_req_o  = (st_q == S_FETCH);
  assign dsc_addr_o = cda_i + AW'(idx_q);
  // link word is the fourth and final fetch
  assign fetched_w  = dsc_req_o && (idx_q == 2'd3) && dsc_ack_i && !dsc_err_i && !abort_i;
  assign cp_start_o = fetched_w && (cnt_q != '0);
  assign ev_zlen_o  = fetched_w && (cnt_q == '0);
  assign ev_merr_o  = !abort_i && ((dsc_req_o && dsc_ack_i && dsc_err_i) ||
                                   ((st_q == S_COPY) && cp_err_i));
  assign fin_w      = !abort_i && (st_q == S_COPY) && cp_done_i;
  assign ev_done_o  = fin_w && last_q;
  assign cda_ld_o   = fin_w && !last_q;
  assign cda_nxt_o  = nxt_q;
  assign halt_w     = abort_i || ev_merr_o || ev_zlen_o;
  assign cp_src_o   = src_q;
  assign cp_dst_o   = dst_q;
  assign cp_cnt_o   = cnt_q;
  assign busy_o     = (st_q != S_IDLE);
  assign halted_o   = halted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      idx_q    <= '0;
      cnt_q    <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      nxt_q    <= '0;
      last_q   <= 1'b0;
      halted_q <= 1'b0;
    end else if (go_i) begin
      st_q     <= S_FETCH;
      idx_q    <= '0;
      halted_q <= 1'b0;
    end else if (halt_w) begin
      st_q     <= S_IDLE;
      halted_q <= 1'b1;
    end else begin
      unique case (st_q)
        S_FETCH: if (dsc_ack_i) begin
          unique case (idx_q)
            2'd0: cnt_q <= dsc_rdata_i[CW-1:0];
            2'd1: src_q <= dsc_rdata_i[AW-1:0];
            2'd2: dst_q <= dsc_rdata_i[AW-1:0];
            default: begin
              nxt_q  <= {dsc_rdata_i[AW-1:2], 2'b00};
              last_q <= dsc_rdata_i[0];
              st_q   <= S_COPY;
            end
          endcase
          idx_q <= idx_q + 2'd1;
        end
        S_COPY: if (fin_w) begin
          st_q  <= last_q ? S_IDLE : S_FETCH;
          idx_q <= '0;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldma_chan.sv
module ldma_chan
  import ldma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              dsc_req_o,
  output logic [AW-1:0]     dsc_addr_o,
  input  logic              dsc_ack_i,
  input  logic              dsc_err_i,
  input  logic [31:0]       dsc_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              irq_o
);
  logic go_w, abort_w, busy_w, halted_w;
  logic ev_done_w, ev_zlen_w, ev_merr_w, cda_ld_w;
  logic [AW-1:0] cda_w, cda_nxt_w, cp_src_w, cp_dst_w;
  logic [CW-1:0] cp_cnt_w;
  logic cp_start_w, cp_done_w, cp_err_w;

  ldma_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy_w), .halted_i(halted_w), .ev_done_i(ev_done_w),
    .ev_zlen_i(ev_zlen_w), .ev_merr_i(ev_merr_w), .cda_ld_i(cda_ld_w),
    .cda_nxt_i(cda_nxt_w), .cda_o(cda_w), .go_o(go_w), .abort_o(abort_w),
    .irq_o
  );

  ldma_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk_i, .rst_ni, .go_i(go_w), .abort_i(abort_w), .cda_i(cda_w),
    .dsc_req_o, .dsc_addr_o, .dsc_ack_i, .dsc_err_i, .dsc_rdata_i,
    .cp_start_o(cp_start_w), .cp_src_o(cp_src_w), .cp_dst_o(cp_dst_w),
    .cp_cnt_o(cp_cnt_w), .cp_done_i(cp_done_w), .cp_err_i(cp_err_w),
    .busy_o(busy_w), .halted_o(halted_w), .ev_done_o(ev_done_w),
    .ev_zlen_o(ev_zlen_w), .ev_merr_o(ev_merr_w), .cda_ld_o(cda_ld_w),
    .cda_nxt_o(cda_nxt_w)
  );

  ldma_copy #(.AW(AW), .CW(CW)) u_copy (
    .clk_i, .rst_ni, .start_i(cp_start_w), .abort_i(abort_w),
    .src_i(cp_src_w), .dst_i(cp_dst_w), .cnt_i(cp_cnt_w),
    .done_o(cp_done_w), .err_o(cp_err_w),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_ack_i, .mem_err_i, .mem_rdata_i
  );
endmodule

// File: rtl/ldma_chk.sv
module ldma_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [1:0]    reg_addr_i,
  input logic [31:0]   reg_wdata_i,
  input logic          busy_i,
  input logic          halted_i,
  input logic          ev_done_i,
  input logic          ev_zlen_i,
  input logic          dsc_req_i,
  input logic          dsc_ack_i,
  input logic [AW-1:0] dsc_addr_i,
  input logic          mem_req_i,
  input logic          mem_ack_i,
  input logic          mem_we_i,
  input logic [AW-1:0] mem_addr_i
);
  logic abort_w;
  assign abort_w = reg_we_i && (reg_addr_i == 2'd0) && reg_wdata_i[1] && busy_i;

  // R5
  busy_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_i && halted_i));
  // R13
  dsc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsc_req_i && !dsc_ack_i && !abort_w |=> dsc_req_i && $stable(dsc_addr_i));
  // R13
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_ack_i && !abort_w |=> mem_req_i && $stable(mem_addr_i) && $stable(mem_we_i));
  // R3
  port_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dsc_req_i && mem_req_i));
  // R4
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !dsc_req_i && !mem_req_i);
  // R7
  abort_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_w |=> !busy_i && halted_i && !mem_req_i);
  // R8
  zlen_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_zlen_i |-> !mem_req_i ##1 !busy_i && halted_i);
  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_done_i |=> !busy_i && !halted_i);
endmodule

bind ldma_chan ldma_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .busy_i(busy_w), .halted_i(halted_w),
  .ev_done_i(ev_done_w), .ev_zlen_i(ev_zlen_w), .dsc_req_i(dsc_req_o),
  .dsc_ack_i(dsc_ack_i), .dsc_addr_i(dsc_addr_o), .mem_req_i(mem_req_o),
  .mem_ack_i(mem_ack_i), .mem_we_i(mem_we_o), .mem_addr_i(mem_addr_o)
);

// File: tb/sim_ldma_chan.sv
module sim_ldma_chan;
  localparam int AW = 16;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic dsc_req, dsc_ack, dsc_err;
  logic [AW-1:0] dsc_addr;
  logic [31:0] dsc_rdata;
  logic mem_req, mem_we, mem_ack, mem_err;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic irq;

  logic [31:0] dmem [256];
  logic [7:0]  bmem [1024];
  logic [7:0]  ref_m [1024];
  logic [7:0]  snap [1024];
  logic dsc_rdy = 1'b1, mem_rdy = 1'b1, stall_en = 1'b0;
  int err_dsc = -1, err_mem = -1;
  int total = 0, bad = 0;

  ldma_chan #(.AW(AW), .CW(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .dsc_req_o(dsc_req), .dsc_addr_o(dsc_addr), .dsc_ack_i(dsc_ack),
    .dsc_err_i(dsc_err), .dsc_rdata_i(dsc_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_err_i(mem_err),
    .mem_rdata_i(mem_rdata), .irq_o(irq)
  );

  assign dsc_ack   = dsc_req & dsc_rdy;
  assign dsc_rdata = dmem[dsc_addr[7:0]];
  assign dsc_err   = dsc_ack && (int'(dsc_addr) == err_dsc);
  assign mem_ack   = mem_req & mem_rdy;
  assign mem_rdata = bmem[mem_addr[9:0]];
  assign mem_err   = mem_ack && (int'(mem_addr) == err_mem);

  always @(posedge clk)
    if (mem_req && mem_we && mem_ack && !mem_err) bmem[mem_addr[9:0]] <= mem_wdata;

  always @(negedge clk) begin
    dsc_rdy <= !stall_en || ($urandom % 3 != 0);
    mem_rdy <= !stall_en || ($urandom % 3 != 0);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] s;
    int n = 0;
    do begin rd(2'd1, s); n++; end while (s[4] && n < 20000);
    if (s[4]) chk(1'b0, req, "busy timeout", s, 0);
  endtask

  task automatic put_desc(input int a, input int c, input int s, input int d, input int nx);
    dmem[a] = c; dmem[a+1] = s; dmem[a+2] = d; dmem[a+3] = nx;
  endtask

  task automatic launch(input int a, input logic [31:0] mode_bits);
    wr(2'd1, 32'h7);
    wr(2'd0, 32'h0);
    wr(2'd2, a);
    wr(2'd0, 32'h1 | mode_bits);
  endtask

  function automatic int mem_diff();
    int n = 0;
    for (int i = 0; i < 1024; i++) if (bmem[i] !== ref_m[i]) n++;
    return n;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) dmem[i] = '0;
    for (int i = 0; i < 1024; i++) bmem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk(v == 0, "R1", "mode", v, 0);
    rd(2'd1, v); chk(v == 0, "R1", "status", v, 0);
    rd(2'd2, v); chk(v == 0, "R1", "cda", v, 0);
    chk(irq == 1'b0, "R1", "irq", irq, 0);

    // R2 R6 R11 single descriptor
    put_desc(16, 5, 100, 300, 1);
    for (int i = 0; i < 1024; i++) ref_m[i] = bmem[i];
    for (int k = 0; k < 5; k++) ref_m[300+k] = bmem[100+k];
    launch(16, 32'h4);
    rd(2'd1, v); chk(v[4] == 1'b1, "R5", "busy while running", v[4], 1);
    wait_idle("R2");
    chk(mem_diff() == 0, "R2", "copied bytes mismatching", mem_diff(), 0);
    rd(2'd1, v); chk(v == 32'h1, "R6", "status after chain", v, 32'h1);
    chk(irq == 1'b1, "R6", "irq on done", irq, 1);
    rd(2'd2, v); chk(v == 16, "R11", "cda after single", v, 16);

    // R10 write-one-to-clear
    wr(2'd1, 32'h0);
    rd(2'd1, v); chk(v[0] == 1'b1, "R10", "bit kept on zero write", v[0], 1);
    wr(2'd1, 32'h1);
    rd(2'd1, v); chk(v == 0, "R10", "bit cleared on one write", v, 0);
    chk(irq == 1'b0, "R10", "irq after clear", irq, 0);

    // R4 start bit still set: rewrite does nothing
    for (int k = 0; k < 5; k++) bmem[100+k] = bmem[100+k] ^ 8'h5a;
    for (int i = 0; i < 1024; i++) ref_m[i] = bmem[i];
    wr(2'd0, 32'h5);
    repeat (20) @(negedge clk);
    rd(2'd1, v); chk(v == 0, "R4", "status after repeated start", v, 0);
    chk(mem_diff() == 0, "R4", "bytes moved on repeated start", mem_diff(), 0);
    wr(2'd0, 32'h0);
    wr(2'd0, 32'h5);
    wait_idle("R4");
    for (int k = 0; k < 5; k++) ref_m[300+k] = bmem[100+k];
    chk(mem_diff() == 0, "R4", "restart after clearing start", mem_diff(), 0);

    // R2 R3 R11 random chains with a trap past the end
    for (int it = 0; it < 24; it++) begin
      int n, s0, sp, dp, a, na, c, lastA;
      n = 1 + int'($urandom % 4);
      s0 = int'($urandom % 64);
      sp = int'($urandom % 64);
      dp = 512 + int'($urandom % 64);
      stall_en = it[0];
      for (int i = 0; i < 1024; i++) bmem[i] = 8'($urandom);
      for (int i = 0; i < 1024; i++) ref_m[i] = bmem[i];
      lastA = 0;
      for (int i = 0; i < n; i++) begin
        a  = ((s0 + i * 7) % 64) * 4;
        na = ((s0 + (i + 1) * 7) % 64) * 4;
        c  = 1 + int'($urandom % 12);
        put_desc(a, c, sp, dp, na | ((i == n - 1) ? 1 : 0));
        for (int k = 0; k < c; k++) ref_m[dp+k] = ref_m[sp+k];
        sp += c + int'($urandom % 4);
        dp += c + int'($urandom % 4);
        lastA = a;
      end
      put_desc(((s0 + n * 7) % 64) * 4, 8, sp, dp, 1);
      launch(((s0 % 64) * 4), 32'h4);
      wait_idle("R3");
      chk(mem_diff() == 0, "R3", "chain result bytes mismatching", mem_diff(), 0);
      rd(2'd1, v); chk(v == 32'h1, "R3", "status after chain", v, 32'h1);
      rd(2'd2, v); chk(v == lastA, "R11", "cda holds last descriptor", v, lastA);
    end
    stall_en = 1'b0;

    // R11 progress readback
    begin
      int addrs[3];
      int prev = 0, mx = 0;
      bit ok = 1'b1;
      addrs[0] = 40; addrs[1] = 120; addrs[2] = 8;
      put_desc(40, 16, 0, 600, 120);
      put_desc(120, 16, 20, 640, 8);
      put_desc(8, 16, 40, 680, 1);
      launch(40, 32'h0);
      for (int j = 0; j < 200; j++) begin
        int idx = -1;
        rd(2'd2, v);
        for (int q = 0; q < 3; q++) if (v == addrs[q]) idx = q;
        if (idx < prev) ok = 1'b0;
        else prev = idx;
        if (idx > mx) mx = idx;
      end
      wait_idle("R11");
      chk(ok && mx == 2, "R11", "cda progress order", mx, 2);
    end

    // R8 R12 zero-length descriptor after a valid one
    for (int i = 0; i < 1024; i++) ref_m[i] = bmem[i];
    put_desc(60, 3, 200, 800, 64);
    put_desc(64, 0, 210, 810, 1);
    for (int k = 0; k < 3; k++) ref_m[800+k] = bmem[200+k];
    launch(60, 32'h0);
    wait_idle("R8");
    rd(2'd1, v); chk(v == 32'h22, "R8", "status after zero count", v, 32'h22);
    chk(mem_diff() == 0, "R8", "bytes after zero count", mem_diff(), 0);
    chk(irq == 1'b0, "R12", "irq with error enable clear", irq, 0);
    wr(2'd0, 32'h8);
    chk(irq == 1'b1, "R12", "irq with error enable set", irq, 1);
    wr(2'd1, 32'h2);
    chk(irq == 1'b0, "R12", "irq after clearing error", irq, 0);

    // R9 data port error mid-copy
    for (int i = 0; i < 1024; i++) ref_m[i] = bmem[i];
    put_desc(68, 6, 40, 900, 1);
    for (int k = 0; k < 2; k++) ref_m[900+k] = bmem[40+k];
    err_mem = 42;
    launch(68, 32'h8);
    wait_idle("R9");
    err_mem = -1;
    rd(2'd1, v); chk(v == 32'h24, "R9", "status after data error", v, 32'h24);
    chk(mem_diff() == 0, "R9", "bytes before data error", mem_diff(), 0);
    chk(irq == 1'b1, "R12", "irq on data error", irq, 1);

    // R9 descriptor port error
    put_desc(72, 4, 50, 950, 1);
    err_dsc = 74;
    launch(72, 32'h0);
    wait_idle("R9");
    err_dsc = -1;
    rd(2'd1, v); chk(v == 32'h24, "R9", "status after fetch error", v, 32'h24);
    chk(mem_diff() == 0, "R9", "no bytes after fetch error", mem_diff(), 0);

    // R7 abort a long copy
    put_desc(76, 200, 0, 700, 1);
    for (int i = 0; i < 200; i++) bmem[700+i] = ~bmem[i];
    launch(76, 32'h4);
    repeat (40) @(negedge clk);
    wr(2'd0, 32'h2);
    rd(2'd1, v); chk(v == 32'h20, "R7", "status after abort", v, 32'h20);
    for (int i = 0; i < 1024; i++) snap[i] = bmem[i];
    repeat (60) @(negedge clk);
    begin
      int n = 0;
      for (int i = 0; i < 1024; i++) if (bmem[i] !== snap[i]) n++;
      chk(n == 0, "R7", "writes after abort", n, 0);
    end
    chk(bmem[899] == ~bmem[199], "R7", "tail byte untouched", bmem[899], ~bmem[199]);
    chk(irq == 1'b0, "R7", "no done irq after abort", irq, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule